// File: doc/BRIEF.md
# Overload Fault Timer with Latch-Off

This block turns a per-cycle overcurrent indication into a protective shutdown decision for a switching power stage. A period counts as faulty when the overcurrent flag is asserted in any clock cycle of that period, including the cycle that carries the period tick. The first faulty period arms a delay timer. While the timer is armed, it advances on a slow, millisecond-scale tick. When it reaches its configured count, a sticky fault output goes high. That output is meant to gate off the power switch driver.

A short pause in the fault does not reset the accumulated time. Once armed, the timer is dropped and cleared only after a run of consecutive fault-free periods. Any faulty period inside that run starts the clean count again. After the fault output is set, it stays set until one of two things happens. A brown-out reset event or an undervoltage-lockout reset clears it, and the timer then starts again from zero.

Top module: `overload_fault_timer`

## Requirements
- R1: After a synchronous reset, `fault_off` is 0 and the timer is disarmed with a count of zero.
- R2: While armed, the timer counts pulses of `slow_tick`. On the `DELAY_TICKS`-th counted pulse (default 15), `fault_off` rises in the cycle after that pulse and not earlier.
- R3: A period is faulty when `oc_flag` is 1 in any cycle from the previous `period_tick` up to and including the current one. A faulty period arms the timer, and a single-cycle flag pulse, even one that lands only on the tick cycle, is enough.
- R4: Pulses of `slow_tick` that arrive while the timer is disarmed add nothing to the count.
- R5: An armed timer is disarmed and cleared only at the `CLEAN_PERIODS`-th consecutive fault-free period tick (default 3). With fewer clean periods, the accumulated count is kept.
- R6: A faulty period restarts the clean-period run from zero.
- R7: Once set, `fault_off` stays 1 whatever happens on `oc_flag`, `period_tick` and `slow_tick`.
- R8: A `bo_reset` pulse clears `fault_off` in the following cycle. A later fault then needs the full `DELAY_TICKS` again.
- R9: A `uvlo_reset` pulse has the same clearing and restart effect as `bo_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_tick | input | 1 | One-cycle pulse marking the end of a switching period |
| slow_tick | input | 1 | One-cycle pulse of the slow time base that the delay counts |
| oc_flag | input | 1 | Sense level has reached the overcurrent limit |
| bo_reset | input | 1 | One-cycle brown-out reset event |
| uvlo_reset | input | 1 | One-cycle undervoltage-lockout reset |
| fault_off | output | 1 | Latched fault; 1 disables switching |

## Verification
The assertions assume that `period_tick` and `slow_tick` are single-cycle pulses that never share a cycle. They also assume that the two reset events are single-cycle pulses arriving outside tick cycles.

The bench drives every input on the falling edge. It keeps each kind of event on its own cycle, so slow ticks are always separated from period boundaries. Under those conditions, every expiry and every clear lands on one predictable clock edge.

// File: rtl/oft_pkg.sv
package oft_pkg;

    localparam int DEF_DELAY_TICKS   = 15;
    localparam int DEF_CLEAN_PERIODS = 3;

    // width able to hold values 0..n
    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // summary of the period monitor state seen by the top
    typedef struct packed {
        logic armed;
        logic tick_fault;
    } period_state_t;

endpackage

// File: rtl/oft_period_mon.sv
module oft_period_mon
    import oft_pkg::*;
#(
    parameter int CLEAN_PERIODS = DEF_CLEAN_PERIODS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          period_tick,
    input  logic          oc_flag,
    output period_state_t pstate
);
    localparam int CW = cnt_w(CLEAN_PERIODS);

    logic          seen;
    logic          armed;
    logic [CW-1:0] clean_cnt;
    logic          period_faulty;

    assign period_faulty = seen | oc_flag;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            seen      <= 1'b0;
            armed     <= 1'b0;
            clean_cnt <= '0;
        end else if (period_tick) begin
            seen <= 1'b0;
            if (period_faulty) begin
                armed     <= 1'b1;
                clean_cnt <= '0;
            end else if (armed) begin
                if (clean_cnt == CW'(CLEAN_PERIODS - 1)) begin
                    armed     <= 1'b0;
                    clean_cnt <= '0;
                end else begin
                    clean_cnt <= clean_cnt + 1'b1;
                end
            end
        end else if (oc_flag) begin
            seen <= 1'b1;
        end
    end

    assign pstate.armed      = armed;
    assign pstate.tick_fault = period_tick & period_faulty;

    // R3
    arm_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (period_tick && oc_flag && !clr) |=> armed);

    // R5
    disarm_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(armed) |-> ($past(period_tick) || $past(clr)));

    // R6
    clean_run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        clean_cnt < CW'(CLEAN_PERIODS));

endmodule

// File: rtl/oft_delay_timer.sv
module oft_delay_timer
    import oft_pkg::*;
#(
    parameter int DELAY_TICKS = DEF_DELAY_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic armed,
    input  logic slow_tick,
    output logic expire
);
    localparam int TW = cnt_w(DELAY_TICKS);

    logic [TW-1:0] cnt;

    assign expire = armed && slow_tick && (cnt == TW'(DELAY_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || !armed) begin
            cnt <= '0;
        end else if (slow_tick) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < TW'(DELAY_TICKS));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !clr) |=> (cnt == '0));

    // R2
    no_tick_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && !slow_tick && !clr && $past(armed)) |=> $stable(cnt));

endmodule

// File: rtl/overload_fault_timer.sv
module overload_fault_timer
    import oft_pkg::*;
#(
    parameter int DELAY_TICKS   = DEF_DELAY_TICKS,
    parameter int CLEAN_PERIODS = DEF_CLEAN_PERIODS
) (
    input  logic clk,
    input  logic rst,
    input  logic period_tick,
    input  logic slow_tick,
    input  logic oc_flag,
    input  logic bo_reset,
    input  logic uvlo_reset,
    output logic fault_off
);
    period_state_t pstate;
    logic          restart;
    logic          hold_clr;
    logic          expire;

    assign restart  = bo_reset | uvlo_reset;
    assign hold_clr = restart | fault_off;

    oft_period_mon #(.CLEAN_PERIODS(CLEAN_PERIODS)) u_mon (
        .clk        (clk),
        .rst        (rst),
        .clr        (hold_clr),
        .period_tick(period_tick),
        .oc_flag    (oc_flag),
        .pstate     (pstate)
    );

    oft_delay_timer #(.DELAY_TICKS(DELAY_TICKS)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .clr      (hold_clr),
        .armed    (pstate.armed),
        .slow_tick(slow_tick),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            fault_off <= 1'b0;
        end else if (expire) begin
            fault_off <= 1'b1;
        end
    end

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_off && !bo_reset && !uvlo_reset) |=> fault_off);

    // R8
    bo_clear_chk: assert property (@(posedge clk) disable iff (rst)
        bo_reset |=> !fault_off);

    // R9
    uvlo_clear_chk: assert property (@(posedge clk) disable iff (rst)
        uvlo_reset |=> !fault_off);

    // R2
    latch_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_off) |-> ($past(slow_tick) && $past(pstate.armed)));

endmodule

// File: tb/overload_fault_timer_bench.sv
module overload_fault_timer_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic period_tick = 1'b0;
    logic slow_tick = 1'b0;
    logic oc_flag = 1'b0;
    logic bo_reset = 1'b0;
    logic uvlo_reset = 1'b0;
    logic fault_off;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    overload_fault_timer u_overload_fault_timer (
        .clk        (clk),
        .rst        (rst),
        .period_tick(period_tick),
        .slow_tick  (slow_tick),
        .oc_flag    (oc_flag),
        .bo_reset   (bo_reset),
        .uvlo_reset (uvlo_reset),
        .fault_off  (fault_off)
    );

    task automatic check(input logic exp, input string req);
        n_chk++;
        if (fault_off !== exp) begin
            n_bad++;
            $display("FAIL %s: fault_off=%b expected %b at %0t", req, fault_off, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one switching period: flag pulsed mid-period and/or on the tick cycle
    task automatic period(input bit mid, input bit at_tick);
        @(negedge clk);
        oc_flag = mid;
        @(negedge clk);
        oc_flag = 1'b0;
        @(negedge clk);
        period_tick = 1'b1;
        oc_flag = at_tick;
        @(negedge clk);
        period_tick = 1'b0;
        oc_flag = 1'b0;
    endtask

    task automatic slow(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        check(1'b0, "R1 reset state");
    endtask

    task automatic t_expire();
        do_reset();
        period(1, 0);
        slow(14);
        check(1'b0, "R2 before expiry");
        slow(1);
        check(1'b1, "R2 at expiry");
    endtask

    task automatic t_sticky();
        for (int i = 0; i < 4; i++) period(0, 0);
        period(1, 1);
        slow(5);
        check(1'b1, "R7 latch sticky");
    endtask

    task automatic t_bo();
        @(negedge clk);
        bo_reset = 1'b1;
        @(negedge clk);
        bo_reset = 1'b0;
        check(1'b0, "R8 brown-out clears");
        period(1, 0);
        slow(14);
        check(1'b0, "R8 timer restarted");
        slow(1);
        check(1'b1, "R8 re-expiry");
    endtask

    task automatic t_uvlo();
        @(negedge clk);
        uvlo_reset = 1'b1;
        @(negedge clk);
        uvlo_reset = 1'b0;
        check(1'b0, "R9 uvlo clears");
        period(1, 0);
        slow(14);
        check(1'b0, "R9 timer restarted");
        slow(1);
        check(1'b1, "R9 re-expiry");
    endtask

    task automatic t_idle();
        do_reset();
        slow(20);
        check(1'b0, "R4 idle ticks ignored");
        period(1, 0);
        slow(14);
        check(1'b0, "R4 count from zero");
        slow(1);
        check(1'b1, "R4 expiry after arm");
    endtask

    task automatic t_gap();
        do_reset();
        period(1, 0);
        slow(10);
        period(0, 0);
        period(0, 0);
        slow(4);
        check(1'b0, "R5 short gap before expiry");
        slow(1);
        check(1'b1, "R5 count kept over gap");
    endtask

    task automatic t_clear();
        do_reset();
        period(1, 0);
        slow(10);
        for (int i = 0; i < 3; i++) period(0, 0);
        slow(5);
        check(1'b0, "R5 cleared after clean run");
        period(1, 0);
        slow(14);
        check(1'b0, "R5 fresh count");
        slow(1);
        check(1'b1, "R5 fresh expiry");
    endtask

    task automatic t_restart_run();
        do_reset();
        period(1, 0);
        slow(5);
        period(0, 0);
        period(0, 0);
        period(1, 0);
        period(0, 0);
        period(0, 0);
        slow(9);
        check(1'b0, "R6 before expiry");
        slow(1);
        check(1'b1, "R6 clean run restarted");
    endtask

    task automatic t_tick_flag();
        do_reset();
        period(0, 1);
        slow(15);
        check(1'b1, "R3 flag on tick cycle arms");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_expire();
        t_sticky();
        t_bo();
        t_uvlo();
        t_idle();
        t_gap();
        t_clear();
        t_restart_run();
        t_tick_flag();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule